// File: doc/BRIEF.md
# Configuration clock burst generator

This block produces a counted train of pulses on a configuration clock output, derived from the system clock. A sequencer or a processor selects a divide ratio, then writes a pulse count. The write starts the burst, and the block emits exactly that many pulses. When the last pulse has finished its low half, the block sets a sticky completion flag. The flag stays set until the requester writes a one to it.

A typical use is in a device configuration controller. At one step the controller needs a few extra clocks, for example 4. At another it needs a long run, for example 0x5000 pulses. The controller clears any stale completion flag, writes the count, and polls the flag. The register port writes on the clock edge. Reads are combinational from a read address.

Top module: `cfgclk_burst_gen`

## Requirements
- R1: After reset, `cfg_clk` and `busy` are 0, and the control, count and status registers all read 0.
- R2: A write to the count register (address 1, count in bits [15:0]) with a nonzero value N while idle starts a burst. `busy` reads 1 from the cycle after the write, and exactly N pulses appear on `cfg_clk`.
- R3: Each pulse is high for 2^r system clocks and then low for 2^r system clocks. The first high half begins the cycle after the count write. The ratio code r sits in control register bits [7:6] (address 0): 0 selects x1, 1 selects x2, 2 selects x4 and 3 selects x8.
- R4: `busy` stays 1 until the low half of the last pulse ends. `cfg_clk` is 0 whenever `busy` is 0. On the edge where `busy` falls, the done bit becomes 1 (bit 0 of the status register at address 2).
- R5: Writing 1 to status bit 0 clears the done bit. Writing 0 to it leaves the bit unchanged.
- R6: A count write of 0 while idle sets the done bit on that edge. It produces no pulse and leaves `busy` at 0.
- R7: A count write during a burst is ignored. The count register keeps its value and the running burst keeps its pulse total.
- R8: The ratio is captured when a burst starts. A control write during a burst changes the read-back value at once, but does not change the timing of the running burst.
- R9: If the completion edge and a clearing write to the status register fall on the same clock, the done bit ends up set.
- R10: Counts up to 16 bits are supported. A burst of 0x5000 pulses runs to completion with the exact total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 count, 2 status |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Combinational read data |
| cfg_clk | output | 1 | Configuration clock output |
| busy | output | 1 | High while a burst is in progress |

## Verification
The hardest case to reach is a clearing status write that lands on the very edge where the last low half ends, because the flag must then stay set. The stimulus counts system clocks from the count write and places the clearing write on edge 2·2^r·N after it, using ratio x1 and a two-pulse burst. A scoreboard monitor measures the width of every high and low half and the pulse total of every burst against queued expectations. This also catches a count write made mid-burst that wrongly lengthens the burst, and a ratio change that leaks into a running burst.

// File: rtl/cbg_pkg.sv
package cbg_pkg;

    localparam int REG_W     = 32;
    localparam int ADDR_W    = 2;
    localparam int RATIO_LSB = 6;
    localparam int HALF_W    = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd2;

    typedef enum logic [1:0] {
        DIV_X1 = 2'd0,
        DIV_X2 = 2'd1,
        DIV_X4 = 2'd2,
        DIV_X8 = 2'd3
    } div_ratio_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  data;
    } reg_wr_t;

    // last index of a half period, in system clocks
    function automatic logic [HALF_W-1:0] half_last(div_ratio_e r);
        case (r)
            DIV_X1:  return 3'd0;
            DIV_X2:  return 3'd1;
            DIV_X4:  return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/cbg_regs.sv
module cbg_regs
    import cbg_pkg::*;
#(
    parameter int COUNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  reg_wr_t               wr,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic                  busy,
    input  logic                  finish,
    output div_ratio_e            ratio,
    output logic [COUNT_W-1:0]    count_q,
    output logic                  start,
    output logic                  done,
    output logic [REG_W-1:0]      rd_data
);

    logic count_hit;
    logic zero_hit;
    logic ctrl_hit;
    logic clear_hit;

    assign count_hit = wr.en && (wr.addr == ADDR_COUNT) && !busy;
    assign zero_hit  = count_hit && (wr.data[COUNT_W-1:0] == '0);
    assign start     = count_hit && (wr.data[COUNT_W-1:0] != '0);
    assign ctrl_hit  = wr.en && (wr.addr == ADDR_CTRL);
    assign clear_hit = wr.en && (wr.addr == ADDR_STATUS) && wr.data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio   <= DIV_X1;
            count_q <= '0;
            done    <= 1'b0;
        end else begin
            if (ctrl_hit)
                ratio <= div_ratio_e'(wr.data[RATIO_LSB+1:RATIO_LSB]);
            if (count_hit)
                count_q <= wr.data[COUNT_W-1:0];
            // completion wins over a same-cycle clear
            if (finish || zero_hit)
                done <= 1'b1;
            else if (clear_hit)
                done <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_CTRL:   rd_data[RATIO_LSB+1:RATIO_LSB] = ratio;
            ADDR_COUNT:  rd_data = REG_W'(count_q);
            ADDR_STATUS: rd_data[0] = done;
            default:     rd_data = '0;
        endcase
    end

    generate
        if (COUNT_W < REG_W) begin : g_spare
            logic unused_hi;
            assign unused_hi = ^wr.data[REG_W-1:COUNT_W];
        end
    endgenerate

endmodule

// File: rtl/cbg_divider.sv
module cbg_divider
    import cbg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       run,
    input  div_ratio_e ratio,
    output logic       half_end
);

    div_ratio_e        ratio_run;
    logic [HALF_W-1:0] half_cnt;

    assign half_end = run && (half_cnt == half_last(ratio_run));

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_run <= DIV_X1;
            half_cnt  <= '0;
        end else if (start) begin
            ratio_run <= ratio;
            half_cnt  <= '0;
        end else if (run) begin
            half_cnt <= half_end ? '0 : half_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/cbg_pulse.sv
module cbg_pulse #(
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [COUNT_W-1:0] load_count,
    input  logic               half_end,
    output logic               busy,
    output logic               cfg_clk,
    output logic               finish
);

    logic [COUNT_W-1:0] remain;
    logic               last_pulse;

    assign last_pulse = (remain == COUNT_W'(1));
    assign finish     = half_end && !cfg_clk && last_pulse;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cfg_clk <= 1'b0;
            remain  <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            cfg_clk <= 1'b1;
            remain  <= load_count;
        end else if (half_end) begin
            if (cfg_clk) begin
                cfg_clk <= 1'b0;
            end else if (last_pulse) begin
                busy <= 1'b0;
            end else begin
                remain  <= remain - 1'b1;
                cfg_clk <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfgclk_burst_gen.sv
module cfgclk_burst_gen
    import cbg_pkg::*;
#(
    parameter int COUNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic              cfg_clk,
    output logic              busy
);

    reg_wr_t            wr_req;
    div_ratio_e         ratio;
    logic [COUNT_W-1:0] count_q;
    logic               start;
    logic               done_q;
    logic               finish;
    logic               half_end;

    assign wr_req = '{en: wr_en, addr: wr_addr, data: wr_data};

    cbg_regs #(.COUNT_W(COUNT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_req),
        .rd_addr (rd_addr),
        .busy    (busy),
        .finish  (finish),
        .ratio   (ratio),
        .count_q (count_q),
        .start   (start),
        .done    (done_q),
        .rd_data (rd_data)
    );

    cbg_divider u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .run      (busy),
        .ratio    (ratio),
        .half_end (half_end)
    );

    cbg_pulse #(.COUNT_W(COUNT_W)) u_pulse (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .load_count (wr_data[COUNT_W-1:0]),
        .half_end   (half_end),
        .busy       (busy),
        .cfg_clk    (cfg_clk),
        .finish     (finish)
    );

endmodule

// File: rtl/cbg_chk.sv
module cbg_chk
    import cbg_pkg::*;
#(
    parameter int COUNT_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               cfg_clk,
    input logic               done,
    input logic               wr_en,
    input logic [1:0]         wr_addr,
    input logic [COUNT_W-1:0] wr_cnt,
    input logic               wr_bit0,
    input logic [COUNT_W-1:0] count_q
);

    a_r4_idle_clk_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !cfg_clk);

    a_r4_done_at_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r2_pulse_in_burst: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_clk) |-> busy);

    a_r7_count_held: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en && wr_addr == ADDR_COUNT) |=> $stable(count_q));

    a_r5_clear_done: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_en && wr_addr == ADDR_STATUS && wr_bit0) |=> !done);

    a_r6_zero_count: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_en && wr_addr == ADDR_COUNT && wr_cnt == '0)
            |=> (done && !busy));

endmodule

bind cfgclk_burst_gen cbg_chk #(.COUNT_W(COUNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .cfg_clk (cfg_clk),
    .done    (done_q),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_cnt  (wr_data[COUNT_W-1:0]),
    .wr_bit0 (wr_data[0]),
    .count_q (count_q)
);

// File: tb/sim_cfgclk_burst_gen.sv
`timescale 1ns/1ps
module sim_cfgclk_burst_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        cfg_clk;
    logic        busy;

    cfgclk_burst_gen u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cfg_clk(cfg_clk), .busy(busy)
    );

    always #2 clk = ~clk;

    typedef struct { int n; int h; string tag; } exp_t;
    exp_t expq[$];

    int nchk  = 0;
    int nfail = 0;

    task automatic chk(string tag, string what, longint act, longint expv);
        nchk++;
        if (act != expv) begin
            nfail++;
            $display("FAIL %s %s: act=%0d exp=%0d", tag, what, act, expv);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic start_burst(input int n, input int r, input string tag);
        if (n > 0) expq.push_back('{n: n, h: (1 << r), tag: tag});
        wr(2'd1, n);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // monitor: measures every burst and compares with the queue head
    bit in_burst = 0, prev = 0, bad = 0;
    int pulses = 0, hi = 0, lo = 0, total = 0, cur_h = 1, bad_act = 0;

    always @(negedge clk) begin
        if (rst) begin
            in_burst = 0; prev = 0;
        end else if (busy) begin
            if (!in_burst) begin
                in_burst = 1; prev = 0; bad = 0;
                pulses = 0; hi = 0; lo = 0; total = 0;
                if (expq.size() == 0) begin
                    chk("R7", "unexpected burst", 1, 0);
                    cur_h = 1;
                end else cur_h = expq[0].h;
            end
            total++;
            if (cfg_clk) begin
                if (!prev) begin
                    if (pulses > 0 && lo != cur_h) begin bad = 1; bad_act = lo; end
                    pulses++; hi = 1;
                end else hi++;
            end else begin
                if (prev) begin
                    if (hi != cur_h) begin bad = 1; bad_act = hi; end
                    lo = 1;
                end else lo++;
            end
            prev = cfg_clk;
        end else if (in_burst) begin
            in_burst = 0;
            if (lo != cur_h) begin bad = 1; bad_act = lo; end
            if (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                chk(e.tag, "pulse total", pulses, e.n);
                chk(e.tag, "burst length", total, 2 * e.h * e.n);
                chk("R3", "half width", bad ? bad_act : cur_h, cur_h);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R2 watchdog: act=timeout exp=completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1", "cfg_clk", cfg_clk, 0);
        chk("R1", "busy", busy, 0);
        rd(2'd0, v); chk("R1", "ctrl", v, 0);
        rd(2'd1, v); chk("R1", "count", v, 0);
        rd(2'd2, v); chk("R1", "status", v, 0);

        // R2 / R4: four pulses at x1
        start_burst(4, 0, "R2");
        chk("R2", "busy after write", busy, 1);
        chk("R2", "cfg_clk first high", cfg_clk, 1);
        wait_idle();
        rd(2'd2, v); chk("R4", "done after burst", v, 1);
        chk("R4", "cfg_clk idle", cfg_clk, 0);

        // R5 write-one-to-clear
        wr(2'd2, 0); rd(2'd2, v); chk("R5", "write 0 keeps done", v, 1);
        wr(2'd2, 1); rd(2'd2, v); chk("R5", "write 1 clears done", v, 0);

        // R3 each ratio
        for (int r = 1; r < 4; r++) begin
            wr(2'd0, r << 6);
            rd(2'd0, v); chk("R3", "ctrl readback", v, r << 6);
            start_burst(r + 2, r, "R3");
            wait_idle();
            rd(2'd2, v); chk("R3", "done", v, 1);
            wr(2'd2, 1);
        end
        wr(2'd0, 0);

        // R6 zero count
        wr(2'd1, 0);
        rd(2'd2, v); chk("R6", "done on zero", v, 1);
        chk("R6", "busy on zero", busy, 0);
        repeat (4) @(negedge clk);
        chk("R6", "no pulse", cfg_clk, 0);
        wr(2'd2, 1);

        // R7 write during burst ignored
        wr(2'd0, 1 << 6);
        start_burst(6, 1, "R7");
        repeat (3) @(negedge clk);
        wr(2'd1, 2);
        rd(2'd1, v); chk("R7", "count held", v, 6);
        wait_idle();
        wr(2'd2, 1);

        // R8 ratio captured at start
        wr(2'd0, 0);
        start_burst(3, 0, "R8");
        wr(2'd0, 3 << 6);
        rd(2'd0, v); chk("R8", "ctrl readback mid burst", v, 3 << 6);
        wait_idle();
        wr(2'd2, 1);
        wr(2'd0, 0);

        // R9 clear on the completion edge: done stays set
        start_burst(2, 0, "R9");
        repeat (2) @(negedge clk);
        wr(2'd2, 1);
        chk("R9", "busy ended", busy, 0);
        rd(2'd2, v); chk("R9", "done beats clear", v, 1);
        wr(2'd2, 1);

        // R10 long burst
        start_burst('h5000, 0, "R10");
        rd(2'd1, v); chk("R10", "count readback", v, 'h5000);
        wait_idle();
        rd(2'd2, v); chk("R10", "done", v, 1);

        repeat (4) @(negedge clk);
        chk("R2", "queue drained", expq.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule